// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator

This block makes the switching pattern for a five-level cascaded bridge inverter. It compares a sampled sinusoidal reference against four triangular carriers. Each carrier lives in its own amplitude band, and the bands sit directly on top of one another. The result is four comparison bits, one for each band, and a signed output level from -2 to +2. A downstream gate driver maps the level onto the two bridge cells. Dead time and the power stage lie outside this block.

The reference comes from a sine table that a phase accumulator indexes. The four carriers are all derived from one up/down counter. A carrier that must run in opposite phase uses the mirrored count instead of a second counter. A two-bit arrangement input selects one of three carrier arrangements: all bands in phase, the upper pair opposed to the lower pair, or every band opposed to its neighbours. The modulation depth and the phase step per carrier period are plain register inputs. The reference and the depth are captured once per carrier period, at the top of the shared count, so every comparison within a carrier period uses one stable value.

Top module: `mlpwm_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `level` = 0 and `gate_cmp` = 4'b0011, and the counter, phase accumulator and held reference return to 0, 0 and 128 (default parameters).
- R2: The shared count runs 0,1,…,63,62,…,1,0,1,… and changes by exactly one each cycle, so one carrier period is 126 clocks.
- R3: Band k (k = 0..3, band 0 lowest) has the carrier value 64·k + c, where c is either the count or 63 minus the count. `gate_cmp[k]` is 1 exactly when the held reference is strictly greater than that carrier. Because the bands do not overlap, `gate_cmp` is always one of 0000, 0001, 0011, 0111 or 1111.
- R4: `level` is a 3-bit two's-complement value equal to the number of set bits in `gate_cmp` minus 2. Both outputs are registered, so they show the comparison made in the previous cycle.
- R5: With `arr_mode` = 2'b00, no band uses the mirrored count, so all four carriers are in phase.
- R6: With `arr_mode` = 2'b01, bands 0 and 1 use the mirrored count and bands 2 and 3 use the direct count, so the pair above the midpoint is opposed to the pair below it.
- R7: With `arr_mode` = 2'b10, bands 0 and 2 use the mirrored count and bands 1 and 3 use the direct count, so each band is opposed to its neighbours.
- R8: The code `arr_mode` = 2'b11 behaves exactly like 2'b00.
- R9: The held reference and the phase accumulator update only on an edge at which the count equals 63. At other times, changes to `mod_idx` or `phase_inc` have no effect on the outputs until that edge.
- R10: On each such edge, the 16-bit phase accumulator adds `phase_inc` modulo 2^16. The carrier-to-reference frequency ratio is therefore 65536 / `phase_inc`.
- R11: The held reference is 128 + floor(s·`mod_idx`/256). Here s is the table sample at index i, the top 6 bits of the accumulator before the add. The sample is s = ±floor(4·127·q·(32−q)/1024), with q = i mod 32 and the sign negative for i ≥ 32.
- R12: With `mod_idx` = 0, the reference stays at the midpoint and `level` stays at 0 in every arrangement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_mode | input | 2 | Carrier arrangement: 00 in phase, 01 upper/lower opposed, 10 alternating, 11 as 00 |
| mod_idx | input | MI_W (8) | Modulation depth, fraction of full scale in 1/256 steps |
| phase_inc | input | ACC_W (16) | Phase step added once per carrier period |
| gate_cmp | output | 4 | Registered comparison bit per band, bit k = band k |
| level | output | 3 | Registered signed output level, -2 to +2 |

## Verification
The bench keeps a cycle-exact model of the count, the held reference and the accumulator, built from the formulas above. It compares both outputs on every cycle while the arrangement, depth and phase step vary. A design that mirrors the wrong bands shows bit patterns that are shifted by one half carrier period in the affected bands. A design that captures the depth outside the counter peak follows the bench's changes to `mod_idx` within a carrier period and produces mismatches right away.

A fixed reference of 191 clears band 2 only at the top of the count, which measures the carrier period to the cycle. A counter that repeats its end values would show 128 instead of 126. Zero depth must keep the level at 0, and a wrong rounding of negative products misplaces edges in the lower bands.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int N_BANDS = 4;
    localparam int LVL_W   = 3;

    typedef enum logic [1:0] {
        ARR_INPHASE = 2'd0,
        ARR_OPPOSED = 2'd1,
        ARR_ALTERN  = 2'd2,
        ARR_SPARE   = 2'd3
    } arr_e;

    typedef struct packed {
        logic [N_BANDS-1:0]       bits;
        logic signed [LVL_W-1:0]  lvl;
    } gate_t;

    // bands that run on the mirrored count, bit k = band k
    function automatic logic [N_BANDS-1:0] mirror_mask(arr_e a);
        case (a)
            ARR_OPPOSED: return 4'b0011;
            ARR_ALTERN:  return 4'b0101;
            default:     return 4'b0000;
        endcase
    endfunction

    // parabolic sine approximation; amplitude 2^(car_w+1)-1
    function automatic int sine_val(int i, int idx_w, int car_w);
        int half;
        int q;
        int amp;
        int mag;
        half = 2 ** (idx_w - 1);
        q    = i % half;
        amp  = 2 ** (car_w + 1) - 1;
        mag  = (4 * amp * q * (half - q)) / (half * half);
        return (i >= half) ? -mag : mag;
    endfunction

    function automatic int count_set(logic [N_BANDS-1:0] v);
        int n;
        n = 0;
        for (int k = 0; k < N_BANDS; k++) n += int'(v[k]);
        return n;
    endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
    parameter int CAR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CAR_W-1:0] cnt,
    output logic             peak
);
    localparam logic [CAR_W-1:0] CMAX = '1;

    logic rising;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt == CMAX) begin
                rising <= 1'b0;
                cnt    <= cnt - 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                rising <= 1'b1;
                cnt    <= cnt + 1'b1;
            end else begin
                cnt    <= cnt - 1'b1;
            end
        end
    end

    assign peak = (cnt == CMAX);

endmodule

// File: rtl/mlpwm_refgen.sv
module mlpwm_refgen
    import mlpwm_pkg::*;
#(
    parameter int CAR_W = 6,
    parameter int ACC_W = 16,
    parameter int IDX_W = 6,
    parameter int MI_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   peak,
    input  logic [ACC_W-1:0]       phase_inc,
    input  logic [MI_W-1:0]        mod_idx,
    output logic [ACC_W-1:0]       acc,
    output logic [CAR_W+2:0]       ref_q
);
    localparam int SMP_W  = CAR_W + 2;
    localparam int REF_W  = CAR_W + 3;
    localparam int PROD_W = SMP_W + MI_W + 1;
    localparam int LUT_N  = 2 ** IDX_W;
    localparam int MID    = 2 ** (CAR_W + 1);

    logic signed [SMP_W-1:0] lut [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = SMP_W'(sine_val(g, IDX_W, CAR_W));
    end

    logic [IDX_W-1:0]         idx;
    logic signed [SMP_W-1:0]  smp;
    logic signed [MI_W:0]     mi_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] sum;

    assign idx    = acc[ACC_W-1 -: IDX_W];
    assign smp    = lut[idx];
    assign mi_s   = $signed({1'b0, mod_idx});
    assign prod   = PROD_W'(smp) * PROD_W'(mi_s);
    assign scaled = prod >>> MI_W;
    assign sum    = scaled + PROD_W'(MID);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            ref_q <= REF_W'(MID);
        end else if (peak) begin
            acc   <= acc + phase_inc;
            ref_q <= sum[REF_W-1:0];
        end
    end

endmodule

// File: rtl/mlpwm_bands.sv
module mlpwm_bands
    import mlpwm_pkg::*;
#(
    parameter int CAR_W = 6
) (
    input  logic [CAR_W-1:0]   cnt,
    input  logic [CAR_W+2:0]   ref_q,
    input  arr_e               arr,
    output logic [N_BANDS-1:0] hit
);
    localparam int BAND  = 2 ** CAR_W;
    localparam int REF_W = CAR_W + 3;

    logic [N_BANDS-1:0] mirror;
    assign mirror = mirror_mask(arr);

    for (genvar k = 0; k < N_BANDS; k++) begin : g_band
        logic [CAR_W-1:0] local_c;
        logic [REF_W-1:0] carrier;
        // the mirrored count equals CMAX - cnt because CMAX is all ones
        assign local_c = mirror[k] ? ~cnt : cnt;
        assign carrier = REF_W'(k * BAND) + REF_W'(local_c);
        assign hit[k]  = (ref_q > carrier);
    end

endmodule

// File: rtl/mlpwm_core.sv
module mlpwm_core
    import mlpwm_pkg::*;
#(
    parameter int CAR_W = 6,
    parameter int ACC_W = 16,
    parameter int IDX_W = 6,
    parameter int MI_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              arr_mode,
    input  logic [MI_W-1:0]         mod_idx,
    input  logic [ACC_W-1:0]        phase_inc,
    output logic [N_BANDS-1:0]      gate_cmp,
    output logic signed [LVL_W-1:0] level
);
    localparam int REF_W = CAR_W + 3;
    localparam logic [N_BANDS-1:0] RST_BITS = N_BANDS'((1 << (N_BANDS / 2)) - 1);

    logic [CAR_W-1:0]   car_cnt;
    logic               car_peak;
    logic [ACC_W-1:0]   ph_acc;
    logic [REF_W-1:0]   ref_hold;
    logic [N_BANDS-1:0] hit;
    gate_t              gate_q;

    mlpwm_carrier #(.CAR_W(CAR_W)) u_car (
        .clk  (clk),
        .rst  (rst),
        .cnt  (car_cnt),
        .peak (car_peak)
    );

    mlpwm_refgen #(
        .CAR_W (CAR_W),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W),
        .MI_W  (MI_W)
    ) u_ref (
        .clk       (clk),
        .rst       (rst),
        .peak      (car_peak),
        .phase_inc (phase_inc),
        .mod_idx   (mod_idx),
        .acc       (ph_acc),
        .ref_q     (ref_hold)
    );

    mlpwm_bands #(.CAR_W(CAR_W)) u_bands (
        .cnt   (car_cnt),
        .ref_q (ref_hold),
        .arr   (arr_e'(arr_mode)),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q.bits <= RST_BITS;
            gate_q.lvl  <= '0;
        end else begin
            gate_q.bits <= hit;
            gate_q.lvl  <= LVL_W'(count_set(hit)) - LVL_W'(2);
        end
    end

    assign gate_cmp = gate_q.bits;
    assign level    = gate_q.lvl;

endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk #(
    parameter int CAR_W = 6,
    parameter int ACC_W = 16,
    parameter int REF_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [CAR_W-1:0]  cnt,
    input logic              peak,
    input logic [ACC_W-1:0]  acc,
    input logic [ACC_W-1:0]  phase_inc,
    input logic [REF_W-1:0]  ref_q,
    input logic [3:0]        gate_cmp,
    input logic signed [2:0] level
);

    // R1
    rst_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level == 3'sd0 && gate_cmp == 4'b0011));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt == CAR_W'($past(cnt) + 1'b1) || cnt == CAR_W'($past(cnt) - 1'b1)));

    // R3
    cmp_thermo_chk: assert property (@(posedge clk) disable iff (rst)
        ((gate_cmp + 4'd1) & gate_cmp) == 4'd0);

    // R4
    lvl_sum_chk: assert property (@(posedge clk) disable iff (rst)
        int'(level) == $countones(gate_cmp) - 2);

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(peak)) |-> ($stable(ref_q) && $stable(acc)));

    // R10
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(peak)) |-> acc == ACC_W'($past(acc) + $past(phase_inc)));

endmodule

bind mlpwm_core mlpwm_chk #(
    .CAR_W (CAR_W),
    .ACC_W (ACC_W),
    .REF_W (CAR_W + 3)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (car_cnt),
    .peak      (car_peak),
    .acc       (ph_acc),
    .phase_inc (phase_inc),
    .ref_q     (ref_hold),
    .gate_cmp  (gate_cmp),
    .level     (level)
);

// File: tb/sim_mlpwm_core.sv
module sim_mlpwm_core;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        arr_mode = 2'd0;
    logic [7:0]        mod_idx = 8'd0;
    logic [15:0]       phase_inc = 16'd0;
    logic [3:0]        gate_cmp;
    logic signed [2:0] level;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    int m_cnt = 0;
    int m_up  = 1;
    int m_acc = 0;
    int m_ref = 128;

    mlpwm_core u0 (
        .clk       (clk),
        .rst       (rst),
        .arr_mode  (arr_mode),
        .mod_idx   (mod_idx),
        .phase_inc (phase_inc),
        .gate_cmp  (gate_cmp),
        .level     (level)
    );

    always #2 clk = ~clk;

    function automatic int sine_of(int i);
        int q;
        int mag;
        q   = i % 32;
        mag = (4 * 127 * q * (32 - q)) / 1024;
        return (i >= 32) ? -mag : mag;
    endfunction

    function automatic int ref_of(int acc, int mi);
        int p;
        int fl;
        p  = sine_of(acc / 1024) * mi;
        fl = (p >= 0) ? p / 256 : -((-p + 255) / 256);
        return 128 + fl;
    endfunction

    function automatic bit mirrored(int k, int mode);
        if (mode == 1) return (k < 2);
        if (mode == 2) return (k == 0 || k == 2);
        return 1'b0;
    endfunction

    function automatic logic [3:0] exp_bits(int cnt, int rf, int mode);
        logic [3:0] b;
        for (int k = 0; k < 4; k++) begin
            int c;
            c    = mirrored(k, mode) ? 63 - cnt : cnt;
            b[k] = (rf > 64 * k + c);
        end
        return b;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        logic [3:0] eb;
        int el;
        if (rst) eb = 4'b0011;
        else     eb = exp_bits(m_cnt, m_ref, int'(arr_mode));
        el = $countones(eb) - 2;
        @(posedge clk);
        #1;
        if (rst) begin
            m_cnt = 0; m_up = 1; m_acc = 0; m_ref = 128;
        end else begin
            if (m_cnt == 63) begin
                m_ref = ref_of(m_acc, int'(mod_idx));
                m_acc = (m_acc + int'(phase_inc)) % 65536;
            end
            if (m_up == 1) begin
                if (m_cnt == 63) begin m_up = 0; m_cnt = 62; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
                else m_cnt = m_cnt - 1;
            end
        end
        n_chk++;
        if (gate_cmp !== eb || int'(level) != el) begin
            n_bad++;
            $display("FAIL %s outputs: actual bits %b level %0d expected bits %b level %0d",
                     tag, gate_cmp, level, eb, el);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step("R1");
        rst = 1'b0;
    endtask

    task automatic t_reset();
        arr_mode = 2'd2; mod_idx = 8'd200; phase_inc = 16'd999;
        do_reset();
        // R1: released state before any further edge
        chk("R1", int'(level), 0, "level after reset");
        chk("R1", int'(gate_cmp), 3, "bits after reset");
        for (int i = 0; i < 200; i++) step("R1");
    endtask

    task automatic t_mode(int mode, string tag, int inc, int mi, int cycles);
        arr_mode = 2'(mode); mod_idx = 8'(mi); phase_inc = 16'(inc);
        do_reset();
        for (int i = 0; i < cycles; i++) step(tag);
    endtask

    task automatic t_mi_zero();
        arr_mode = 2'd1; mod_idx = 8'd0; phase_inc = 16'd2048;
        do_reset();
        for (int i = 0; i < 4032; i++) begin
            step("R12");
            chk("R12", int'(level), 0, "level at zero depth");
            if (i == 2000) arr_mode = 2'd2;
        end
    endtask

    task automatic t_hold();
        int mi;
        mi = 90;
        arr_mode = 2'd0; mod_idx = 8'(mi); phase_inc = 16'd2048;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step("R9");
            if (i % 5 == 4) begin
                mi = (mi * 37 + 11) % 256;
                mod_idx = 8'(mi);
            end
            if (i % 11 == 3) phase_inc = 16'((i * 97) % 4096);
        end
    endtask

    task automatic t_period();
        int last;
        int gaps;
        last = -1; gaps = 0;
        arr_mode = 2'd0; mod_idx = 8'd128; phase_inc = 16'd16384;
        do_reset();
        for (int i = 0; i < 64; i++) step("R2");
        phase_inc = 16'd0;
        for (int i = 0; i < 600; i++) begin
            step("R2");
            if (i >= 200 && gate_cmp[2] == 1'b0) begin
                if (last >= 0) begin
                    chk("R2", i - last, 126, "carrier period");
                    gaps++;
                end
                last = i;
            end
        end
        chk("R2", (gaps >= 2) ? 1 : 0, 1, "period samples seen");
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mode(0, "R3 R4 R5 R11", 2048, 230, 8064);
        t_mode(1, "R3 R4 R6 R11", 2048, 230, 8064);
        t_mode(2, "R3 R4 R7 R11", 2048, 230, 8064);
        t_mode(3, "R8", 2048, 180, 4032);
        t_mode(2, "R10", 4096, 255, 4032);
        t_mode(1, "R10 R11", 1024, 64, 8064);
        t_mi_zero();
        t_hold();
        t_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule